// File: doc/BRIEF.md
# Two-Wire Configuration Memory Target

This block models the target side of a serial configuration memory while it sits in its programming mode. A host drives a bus clock and shares an open-drain data line with the target. The target oversamples both lines with a fast system clock and decodes start and stop conditions from them. It compares each device address byte against a fixed pattern and a strap input. It then takes a three-byte memory address and either collects a page of write data or streams stored bytes back to the host.

Written bytes first land in a page buffer. A stop condition that follows at least one data byte commits the buffered bytes into the internal array. The commit runs as a timed write cycle, and during that cycle the target ignores the bus. A host finds out when the cycle has ended by sending a start and the device address repeatedly until the target acknowledges. Between operations the target keeps an address counter, so a read with no address phase continues from the last byte accessed.

Top module: `cfgmem_target`

## Requirements
- R1: A falling data edge while the bus clock is high is a start, and a rising data edge while the bus clock is high is a stop. A start at any point, including in the middle of a byte, returns the target to waiting for a device address.
- R2: The target acknowledges a device address byte (sent MSB first) only when bits 7..4 are 1010, bit 3 equals `strap_a_i`, bits 2..1 are 11, and bit 0 selects read (1) or write (0). On any other byte it does not acknowledge and stays released until the next start.
- R3: After a write device address, three memory address bytes are taken MSB first and each is acknowledged. The resulting address is reduced modulo `MEM_BYTES`, so unused upper bits have no effect.
- R4: Data bytes are shifted least significant bit first in both directions, and the target acknowledges every data byte it receives.
- R5: During a write, only the page-offset bits of the address advance, so bytes past the end of a page wrap to the start of that same page.
- R6: A stop that follows at least one write data byte starts a write cycle of max(`WR_CYCLES`, `PAGE_BYTES`) system clocks, during which nothing is acknowledged. A stop that follows only address bytes starts no cycle, and the next device address is acknowledged at once.
- R7: Only the page locations that received bytes are changed by a commit; every other location keeps its previous value.
- R8: The address counter holds the last accessed address plus one (across the whole array after a read, within the page after a write), and a read with no address phase returns the byte at that address.
- R9: During a read, the target sends the next byte each time the host acknowledges. After a host non-acknowledge it releases the line, which stays high for any further clocks until a start or stop.
- R10: The target only ever pulls the data line low, changes its drive only while the bus clock is low, and comes out of reset released, with the array reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_clk_i | input | 1 | Bus clock driven by the host |
| bus_data_i | input | 1 | Level of the shared open-drain data line |
| bus_data_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_a_i | input | 1 | Strap level that device address bit 3 must match |

## Verification
The assertions check the following on every cycle:
- The line stays released while a write cycle runs and whenever the controller is idle.
- The drive changes only while the synchronised bus clock is low.
- Outside a read, the target pulls the line only in an acknowledge slot.
- A commit always starts the write cycle, and the page buffer is never written or re-committed while a commit is running.

The following can only be shown by the bench's scenarios, because they depend on whole transactions:
- Bit order, and wrapping within a page.
- The address counter carrying over between operations.
- Partial-page commits leaving other bytes alone.
- Polling during the write cycle, and aborts caused by a start in mid-byte.

// File: rtl/cfgmem_pkg.sv
// Shared types and helpers for the two-wire configuration memory target.
// Assumes: a device address byte has the fixed pattern 1010 s 11 r, MSB first.
package cfgmem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // released, waiting for a start
        ST_DEV,    // shifting in the device address byte
        ST_ADDR,   // shifting in memory address bytes
        ST_WDATA,  // receiving write data into the page buffer
        ST_RDATA   // sending stored bytes to the host
    } tgt_state_e;

    // True when the received byte selects this target (bit 0 is the direction).
    function automatic logic dev_byte_ok(input logic [7:0] b, input logic strap);
        return b[7:1] == {4'b1010, strap, 2'b11};
    endfunction

endpackage

// File: rtl/cfgmem_bus_sense.sv
// Bus front end: synchronises the bus clock and data lines into clk and
// reports clock edges plus start and stop conditions as one-cycle pulses.
// Assumes: SYNC_STAGES >= 2 and bus levels stable for several clk periods.
module cfgmem_bus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_clk_i,
    input  logic bus_data_i,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_d;
    logic                   sda_d;

    // Synchroniser chains plus one delayed copy for edge detection; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], bus_clk_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], bus_data_i};
            scl_d    <= scl_q;
            sda_d    <= sda_q;
        end
    end

    assign scl_q     = scl_sync[SYNC_STAGES-1];
    assign sda_q     = sda_sync[SYNC_STAGES-1];
    assign scl_rise  = scl_q & ~scl_d;
    assign scl_fall  = ~scl_q & scl_d;
    assign start_det = scl_q & scl_d & sda_d & ~sda_q;
    assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;

endmodule

// File: rtl/cfgmem_page_store.sv
// Storage: byte array, page buffer with per-byte valid flags, and the timed
// commit that copies valid buffer bytes into one array page, one per clock.
// Assumes: MEM_BYTES and PAGE_BYTES are powers of two, MEM_BYTES > PAGE_BYTES.
module cfgmem_page_store #(
    parameter int MEM_BYTES  = 512,
    parameter int PAGE_BYTES = 64,
    parameter int WR_CYCLES  = 1000
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         buf_clear,
    input  logic                                         buf_we,
    input  logic [$clog2(PAGE_BYTES)-1:0]                buf_off,
    input  logic [7:0]                                   buf_wdata,
    input  logic                                         commit_go,
    input  logic [$clog2(MEM_BYTES)-$clog2(PAGE_BYTES)-1:0] commit_page,
    input  logic [$clog2(MEM_BYTES)-1:0]                 rd_addr,
    output logic [7:0]                                   rd_data,
    output logic                                         busy
);
    localparam int AW       = $clog2(MEM_BYTES);
    localparam int PW       = $clog2(PAGE_BYTES);
    localparam int NPW      = AW - PW;
    localparam int BUSY_LEN = (WR_CYCLES > PAGE_BYTES) ? WR_CYCLES : PAGE_BYTES;
    localparam int CW       = $clog2(BUSY_LEN + 1);

    logic [7:0]            mem   [MEM_BYTES];
    logic [7:0]            pbuf  [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvalid;
    logic [NPW-1:0]        page_q;
    logic [CW-1:0]         cnt;
    logic [PW:0]           walk;

    // Page buffer contents; no reset needed because pvalid qualifies every byte.
    always_ff @(posedge clk) begin
        if (buf_we) pbuf[buf_off] <= buf_wdata;
    end

    // Array, valid flags and the write-cycle timer with its commit walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h00;
            pvalid <= '0;
            page_q <= '0;
            cnt    <= '0;
            walk   <= '0;
        end else begin
            if (commit_go) begin
                cnt    <= CW'(BUSY_LEN);
                walk   <= '0;
                page_q <= commit_page;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
                if (walk < (PW+1)'(PAGE_BYTES)) begin
                    if (pvalid[walk[PW-1:0]])
                        mem[{page_q, walk[PW-1:0]}] <= pbuf[walk[PW-1:0]];
                    walk <= walk + 1'b1;
                end
            end
            if (buf_clear)   pvalid <= '0;
            else if (buf_we) pvalid[buf_off] <= 1'b1;
        end
    end

    assign busy    = (cnt != '0);
    assign rd_data = mem[rd_addr];

    // R6: a commit request always opens the write cycle on the next clock.
    a_r6_commit_opens_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        commit_go |=> busy);
    // R6: the controller never asks for a second commit while one runs.
    a_r6_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !commit_go);
    // R7: the buffer being committed is never modified under the walk.
    a_r7_buffer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(buf_we || buf_clear));

endmodule

// File: rtl/cfgmem_target.sv
// Two-wire configuration memory target, programming mode. Decodes device
// address, three address bytes, page writes and current/sequential reads,
// and acknowledges by pulling the data line low.
// Assumes: bus clock phases last several clk periods; power-of-two sizes.
module cfgmem_target
    import cfgmem_pkg::*;
#(
    parameter int MEM_BYTES   = 512,
    parameter int PAGE_BYTES  = 64,
    parameter int WR_CYCLES   = 1000,
    parameter int ADDR_BYTES  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_clk_i,
    input  logic bus_data_i,
    output logic bus_data_pull_o,
    input  logic strap_a_i
);
    localparam int AW  = $clog2(MEM_BYTES);
    localparam int PW  = $clog2(PAGE_BYTES);
    localparam int ACW = $clog2(ADDR_BYTES + 1);

    logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
    logic busy;
    logic [7:0] rd_data;

    tgt_state_e     state;
    logic [3:0]     bitcnt;
    logic [7:0]     rx;
    logic [7:0]     tx;
    logic [AW-1:0]  cur;
    logic [AW-1:0]  addr_acc;
    logic [ACW-1:0] abyte_cnt;
    logic           rw_q;
    logic           got_ack;
    logic           data_seen;
    logic           pull_q;

    logic bit_evt, fall_evt, buf_we, buf_clear, commit_go;

    cfgmem_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk(clk), .rst_n(rst_n), .bus_clk_i(bus_clk_i), .bus_data_i(bus_data_i),
        .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    // Event qualifiers shared by the controller and the storage strobes.
    always_comb begin
        bit_evt   = !busy && !start_det && !stop_det && (state != ST_IDLE);
        fall_evt  = bit_evt && scl_fall;
        buf_we    = fall_evt && (bitcnt == 4'd8) && (state == ST_WDATA);
        buf_clear = fall_evt && (bitcnt == 4'd9) && (state == ST_ADDR)
                    && (abyte_cnt == ACW'(ADDR_BYTES));
        commit_go = !busy && stop_det && (state == ST_WDATA) && data_seen;
    end

    cfgmem_page_store #(
        .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .buf_clear(buf_clear), .buf_we(buf_we),
        .buf_off(cur[PW-1:0]), .buf_wdata(rx), .commit_go(commit_go),
        .commit_page(cur[AW-1:PW]), .rd_addr(cur), .rd_data(rd_data), .busy(busy)
    );

    // Protocol controller: bit counting, acknowledge, address and data handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            rx        <= '0;
            tx        <= '0;
            cur       <= '0;
            addr_acc  <= '0;
            abyte_cnt <= '0;
            rw_q      <= 1'b0;
            got_ack   <= 1'b0;
            data_seen <= 1'b0;
            pull_q    <= 1'b0;
        end else if (busy) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            pull_q <= 1'b0;
        end else if (start_det) begin
            state  <= ST_DEV;
            bitcnt <= '0;
            pull_q <= 1'b0;
        end else if (stop_det) begin
            state     <= ST_IDLE;
            pull_q    <= 1'b0;
            data_seen <= 1'b0;
        end else if (state != ST_IDLE) begin
            if (scl_rise) begin
                bitcnt <= bitcnt + 4'd1;
                if (bitcnt < 4'd8)
                    rx <= (state == ST_WDATA) ? {sda_q, rx[7:1]} : {rx[6:0], sda_q};
                if (bitcnt == 4'd8) got_ack <= !sda_q;
            end
            if (scl_fall) begin
                if (bitcnt == 4'd8) begin
                    unique case (state)
                        ST_DEV: begin
                            if (dev_byte_ok(rx, strap_a_i)) begin
                                pull_q <= 1'b1;
                                rw_q   <= rx[0];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                        ST_ADDR: begin
                            pull_q    <= 1'b1;
                            addr_acc  <= AW'({addr_acc, rx});
                            abyte_cnt <= abyte_cnt + 1'b1;
                        end
                        ST_WDATA: begin
                            pull_q    <= 1'b1;
                            data_seen <= 1'b1;
                            cur <= {cur[AW-1:PW], PW'(cur[PW-1:0] + 1'b1)};
                        end
                        ST_RDATA: begin
                            pull_q <= 1'b0;
                            cur    <= cur + 1'b1;
                        end
                        default: ;
                    endcase
                end else if (bitcnt == 4'd9) begin
                    bitcnt <= '0;
                    unique case (state)
                        ST_DEV: begin
                            if (rw_q) begin
                                state  <= ST_RDATA;
                                tx     <= rd_data;
                                pull_q <= ~rd_data[0];
                            end else begin
                                state     <= ST_ADDR;
                                abyte_cnt <= '0;
                                pull_q    <= 1'b0;
                            end
                        end
                        ST_ADDR: begin
                            pull_q <= 1'b0;
                            if (abyte_cnt == ACW'(ADDR_BYTES)) begin
                                cur       <= addr_acc;
                                state     <= ST_WDATA;
                                data_seen <= 1'b0;
                            end
                        end
                        ST_WDATA: pull_q <= 1'b0;
                        ST_RDATA: begin
                            if (got_ack) begin
                                tx     <= rd_data;
                                pull_q <= ~rd_data[0];
                            end else begin
                                state  <= ST_IDLE;
                                pull_q <= 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end else if (state == ST_RDATA && bitcnt != 4'd0) begin
                    pull_q <= ~tx[bitcnt[2:0]];
                end
            end
        end
    end

    assign bus_data_pull_o = pull_q;

    // R6: no acknowledge or data drive while the write cycle runs.
    a_r6_silent_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !pull_q);
    // R10: the drive only changes while the synchronised bus clock is low.
    a_r10_change_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_q != $past(pull_q)) |-> !scl_q);
    // R2: an idle target leaves the line released.
    a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !pull_q);
    // R4: outside a read, the line is pulled only in the acknowledge slot.
    a_r4_ack_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_q && state != ST_RDATA) |-> (bitcnt == 4'd8 || bitcnt == 4'd9));

endmodule

// File: tb/tb_cfgmem_target.sv
// Scoreboard bench: drivers push expected read bytes into a queue, a monitor
// pops and compares them as bytes arrive from the target.
module tb_cfgmem_target;
    localparam int MEM = 512;
    localparam int PG  = 64;
    localparam int WRC = 400;
    localparam int H   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic host_low = 1'b0;
    logic strap = 1'b0;
    logic pull;
    logic sda_line;

    always #2 clk = ~clk;
    assign sda_line = !(host_low || pull);

    cfgmem_target #(.MEM_BYTES(MEM), .PAGE_BYTES(PG), .WR_CYCLES(WRC), .ADDR_BYTES(3)) dut (
        .clk(clk), .rst_n(rst_n), .bus_clk_i(scl_drv), .bus_data_i(sda_line),
        .bus_data_pull_o(pull), .strap_a_i(strap)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    byte unsigned model [MEM];
    byte unsigned exp_q [$];
    string        tag_q [$];
    byte unsigned got_q [$];

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic byte unsigned dev(input bit a2, input bit rd);
        return {4'b1010, a2, 2'b11, rd};
    endfunction

    function automatic byte unsigned pat(input int i);
        return byte'((i * 37 + 11) & 255);
    endfunction

    task automatic bus_start;
        host_low = 1'b0; tick(H);
        scl_drv = 1'b1;  tick(H);
        host_low = 1'b1; tick(H);
        scl_drv = 1'b0;  tick(H);
    endtask

    task automatic bus_stop;
        host_low = 1'b1; tick(H);
        scl_drv = 1'b1;  tick(H);
        host_low = 1'b0; tick(H);
    endtask

    task automatic clk_bit(input bit v, output bit s);
        host_low = !v;  tick(H);
        scl_drv = 1'b1; tick(H/2);
        s = sda_line;   tick(H/2);
        scl_drv = 1'b0; tick(2);
    endtask

    task automatic send_byte(input byte unsigned b, input bit lsb_first, output bit acked);
        bit s;
        for (int i = 0; i < 8; i++) clk_bit(lsb_first ? b[i] : b[7-i], s);
        clk_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input bit give_ack);
        bit s;
        byte unsigned b;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(!give_ack, s);
        got_q.push_back(b);
    endtask

    task automatic exp_push(input byte unsigned v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic set_addr(input int addr, output bit ok);
        bit a;
        bus_start;
        send_byte(dev(0, 0), 0, a); ok = a;
        for (int k = 2; k >= 0; k--) begin
            send_byte(byte'((addr >> (8 * k)) & 255), 0, a);
            ok = ok & a;
        end
    endtask

    task automatic wait_ready(output int polls);
        bit a;
        polls = 0;
        do begin
            bus_start;
            send_byte(dev(0, 0), 0, a);
            polls++;
        end while (!a && polls < 40);
        bus_stop;
    endtask

    task automatic rand_read(input int addr, input int n, input string tag);
        bit ok, a;
        set_addr(addr, ok);
        bus_start;
        send_byte(dev(0, 1), 0, a);
        check(ok && a, "R3 random read setup acked", int'(ok && a), 1);
        for (int k = 0; k < n; k++) begin
            exp_push(model[(addr + k) % MEM], tag);
            recv_byte(k != n - 1);
        end
        bus_stop;
    endtask

    // Monitor: compares each received byte against the scoreboard head.
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0) begin
                byte unsigned g;
                g = got_q.pop_front();
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected byte", g, 0);
                end else begin
                    byte unsigned e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(g == e, t, g, e);
                end
            end
        end
    end

    initial begin
        tick(150000);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        bit ok, a;
        int polls, nacks;
        for (int i = 0; i < MEM; i++) model[i] = 8'h00;
        tick(10);
        rst_n = 1'b1;
        tick(6);
        check(pull == 1'b0, "R10 line released after reset", pull, 0);

        // R3 R4 R5: full page from offset 5 of page 1, wraps inside the page.
        set_addr(24'h000045, ok);
        check(ok, "R3 three address bytes acked", ok, 1);
        nacks = 0;
        for (int i = 0; i < PG; i++) begin
            send_byte(pat(i), 1, a);
            if (!a) nacks++;
            model[8'h40 + ((5 + i) & (PG - 1))] = pat(i);
        end
        check(nacks == 0, "R4 every data byte acked", nacks, 0);
        bus_stop;

        // R6: polled during the write cycle, then acknowledged once it ends.
        bus_start;
        send_byte(dev(0, 0), 0, a);
        check(!a, "R6 no ack during write cycle", a, 0);
        wait_ready(polls);
        check(polls < 40, "R6 write cycle ends and ack returns", polls, 1);

        // R8: current address after the write is last written + 1 in the page.
        bus_start;
        send_byte(dev(0, 1), 0, a);
        check(a, "R8 current address read acked", a, 1);
        exp_push(model[8'h45], "R8 current address after write");
        recv_byte(1'b0);
        bus_stop;

        // R7: partial page write leaves neighbours intact.
        set_addr(24'h000085, ok);
        send_byte(8'hA5, 1, a);
        send_byte(8'h3C, 1, a);
        model[8'h85] = 8'hA5;
        model[8'h86] = 8'h3C;
        bus_stop;
        wait_ready(polls);
        rand_read(24'h000084, 4, "R7 partial page commit");

        // R5 R9: sequential read across the wrapped page and into the next one.
        rand_read(24'h000043, PG, "R5 page wrap and sequential read");

        // R8 R9: current address continues at 0x83; after nack the line is released.
        bus_start;
        send_byte(dev(0, 1), 0, a);
        for (int k = 0; k < 3; k++) begin
            exp_push(model[8'h83 + k], "R8 current address after read");
            recv_byte(k != 2);
        end
        exp_push(8'hFF, "R9 released after host nack");
        recv_byte(1'b0);
        bus_stop;

        // R3: upper address bits beyond the array are ignored.
        rand_read(24'h00FE45, 1, "R3 address modulo array size");

        // R2: strap mismatch, wrong fixed bits, then a matching strap.
        bus_start;
        send_byte(dev(1, 1), 0, a);
        check(!a, "R2 strap mismatch not acked", a, 0);
        send_byte(8'h00, 0, a);
        check(!a, "R2 silent until next start", a, 0);
        bus_start;
        send_byte(8'hE7, 0, a);
        check(!a, "R2 wrong fixed bits not acked", a, 0);
        bus_stop;
        strap = 1'b1;
        bus_start;
        send_byte(dev(1, 0), 0, a);
        check(a, "R2 matching strap acked", a, 1);
        bus_stop;
        strap = 1'b0;

        // R6: stop after address bytes only starts no write cycle.
        set_addr(24'h000100, ok);
        bus_stop;
        bus_start;
        send_byte(dev(0, 0), 0, a);
        check(a, "R6 no write cycle without data", a, 1);
        bus_stop;
        rand_read(24'h000100, 1, "R6 nothing written without data");

        // R1: a start in mid-byte restarts the device address phase.
        set_addr(24'h000046, ok);
        bus_start;
        clk_bit(1'b1, a);
        clk_bit(1'b0, a);
        clk_bit(1'b1, a);
        bus_start;
        send_byte(dev(0, 1), 0, a);
        check(a, "R1 start mid-byte restarts address phase", a, 1);
        exp_push(model[8'h46], "R1 read after mid-byte start");
        recv_byte(1'b0);
        bus_stop;

        tick(20);
        check(exp_q.size() == 0, "R4 all expected bytes received", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule